// File: doc/BRIEF.md
# Dual-Issue Instruction Pair Dispatcher

This block sits between a small instruction queue and two execution pipelines. Each cycle it looks at the 32-bit word at the head of the queue. It decides whether that word holds one long instruction or two short ones. For two short ones, it also decides whether they go out together in one cycle or one after the other. It then gives each instruction a destination pipeline based on a two-bit operation class that a predecoder supplies for each halfword.

Pipeline 1 is the only pipeline that takes memory and control-transfer operations. Pipeline 2 is the only one that takes multiply-accumulate operations. Arithmetic and logical work fits either pipeline. A pair that is marked for parallel issue but cannot be placed under these limits is split over two cycles. The queue is popped through `q_advance` only when the last instruction of the head word is accepted downstream.

Issue slot 0 always carries the older instruction and slot 1 the younger, so program order can be read directly from the slots. The pipe field of each slot says where that instruction goes.

Top module: `pair_dispatch`

## Requirements
- R1: After reset no half-issued word is remembered. While `q_valid` is 0, both slot valids, both pipe fields, both instruction buses and `q_advance` are 0.
- R2: A word with bit 31 set is one long instruction. It appears whole on `s0_insn` with `s1_valid` low, and `q_advance` follows `dn_ready` in the same cycle.
- R3: A word with bit 31 clear and bit 15 clear is a sequential pair. In the first accepted cycle, `s0_insn` carries bits 31..16 zero-extended and `q_advance` is 0. In the next accepted cycle it carries bits 15..0 and `q_advance` is 1.
- R4: A word with bit 31 clear and bit 15 set is a parallel pair. When the pair is legal, slot 0 carries bits 31..16 and slot 1 carries bits 15..0, both valid in one cycle, with `q_advance` equal to `dn_ready`.
- R5: Class codes are 00 arithmetic/logic, 01 load/store, 10 jump/branch and 11 multiply-accumulate. A pipe field of 0 means pipeline 1 and 1 means pipeline 2. Classes 01 and 10 always get pipe 0, and class 11 always gets pipe 1.
- R6: In a legal pair the two slots get different pipes. An older arithmetic instruction yields pipeline 1 (so takes pipe 1) when the younger one is of class 01 or 10. Otherwise the older instruction takes pipe 0, unless it is of class 11.
- R7: A parallel pair in which both halves need pipeline 1 (classes 01/10) or both are class 11 is issued like a sequential pair: older first, younger in the next accepted cycle.
- R8: While `dn_ready` is 0 nothing is consumed. The issue phase and the presented slots stay unchanged, and `q_advance` is 0.
- R9: An arithmetic/logic instruction issued alone gets pipe 0 with the default parameter setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_valid | input | 1 | Head of queue holds a word |
| q_word | input | 32 | Head fetch word |
| q_cls_a | input | 2 | Class of bits 31..16 (or of the long instruction) |
| q_cls_b | input | 2 | Class of bits 15..0 |
| dn_ready | input | 1 | Pipelines accept the presented slots |
| q_advance | output | 1 | Pop the queue head this cycle |
| s0_valid | output | 1 | Slot 0 (older) holds an instruction |
| s0_pipe | output | 1 | Slot 0 destination, 0 = pipeline 1 |
| s0_insn | output | 32 | Slot 0 instruction bits |
| s1_valid | output | 1 | Slot 1 (younger) holds an instruction |
| s1_pipe | output | 1 | Slot 1 destination, 0 = pipeline 1 |
| s1_insn | output | 32 | Slot 1 instruction bits, zero-extended |

## Verification
The slot outputs and `q_advance` are due in the same cycle as the head word and `dn_ready`, because they are combinational from those inputs and one phase bit. The phase bit itself changes only at the next rising edge after an accepted cycle. The bench therefore drives inputs just after a falling edge and compares all outputs a quarter period later, before the rising edge. A bench-side phase flag is updated at that edge from the expected accept and advance values, so the second half of a split or sequential word is checked one accepted cycle later, however many stalled cycles come between.

// File: rtl/pd_pkg.sv
package pd_pkg;

   typedef enum logic [1:0] {
      CLS_ALU    = 2'b00,
      CLS_MEM    = 2'b01,
      CLS_BRANCH = 2'b10,
      CLS_MAC    = 2'b11
   } op_cls_e;

   typedef enum logic [1:0] {
      FMT_LONG = 2'b00,
      FMT_SEQ  = 2'b01,
      FMT_PAR  = 2'b10
   } word_fmt_e;

   // pipe field encoding: 0 selects pipeline 1, 1 selects pipeline 2
   localparam logic PIPE_ONE = 1'b0;
   localparam logic PIPE_TWO = 1'b1;

   function automatic logic only_pipe_one(op_cls_e c);
      return (c == CLS_MEM) || (c == CLS_BRANCH);
   endfunction

   function automatic logic only_pipe_two(op_cls_e c);
      return (c == CLS_MAC);
   endfunction

endpackage

// File: rtl/pd_format.sv
module pd_format
   import pd_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  logic [2*HALF_W-1:0] word,
   output word_fmt_e           fmt,
   output logic [HALF_W-1:0]   hw_old,
   output logic [HALF_W-1:0]   hw_young
);
   localparam int WORD_W = 2 * HALF_W;

   assign hw_old   = word[WORD_W-1:HALF_W];
   assign hw_young = word[HALF_W-1:0];

   always_comb begin
      if (word[WORD_W-1])
         fmt = FMT_LONG;
      else if (word[HALF_W-1])
         fmt = FMT_PAR;
      else
         fmt = FMT_SEQ;
   end

endmodule

// File: rtl/pd_route.sv
module pd_route
   import pd_pkg::*;
#(
   parameter bit LONE_ALU_PIPE = 1'b0
) (
   input  op_cls_e cls_old,
   input  op_cls_e cls_young,
   output logic    pair_ok,
   output logic    pair_pipe_old,
   output logic    pair_pipe_young,
   output logic    lone_pipe_old,
   output logic    lone_pipe_young
);
   logic alu_default;
   logic one_old, one_young, two_old, two_young;

   generate
      if (LONE_ALU_PIPE == 1'b0) begin : g_alu_p1
         assign alu_default = PIPE_ONE;
      end else begin : g_alu_p2
         assign alu_default = PIPE_TWO;
      end
   endgenerate

   assign one_old   = only_pipe_one(cls_old);
   assign one_young = only_pipe_one(cls_young);
   assign two_old   = only_pipe_two(cls_old);
   assign two_young = only_pipe_two(cls_young);

   assign pair_ok = !(one_old && one_young) && !(two_old && two_young);

   always_comb begin
      if (two_old || (!one_old && one_young))
         pair_pipe_old = PIPE_TWO;
      else
         pair_pipe_old = PIPE_ONE;
      pair_pipe_young = ~pair_pipe_old;
   end

   assign lone_pipe_old   = two_old   ? PIPE_TWO : (one_old   ? PIPE_ONE : alu_default);
   assign lone_pipe_young = two_young ? PIPE_TWO : (one_young ? PIPE_ONE : alu_default);

endmodule

// File: rtl/pd_phase.sv
module pd_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic finish,
   output logic pend_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (accept)
         pend_q <= !finish;
   end
endmodule

// File: rtl/pair_dispatch.sv
module pair_dispatch
   import pd_pkg::*;
#(
   parameter int HALF_W        = 16,
   parameter bit LONE_ALU_PIPE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                q_valid,
   input  logic [2*HALF_W-1:0] q_word,
   input  logic [1:0]          q_cls_a,
   input  logic [1:0]          q_cls_b,
   input  logic                dn_ready,
   output logic                q_advance,
   output logic                s0_valid,
   output logic                s0_pipe,
   output logic [2*HALF_W-1:0] s0_insn,
   output logic                s1_valid,
   output logic                s1_pipe,
   output logic [2*HALF_W-1:0] s1_insn
);
   localparam int WORD_W = 2 * HALF_W;

   generate
      if (HALF_W < 2) begin : g_bad_width
         $error("pair_dispatch: HALF_W must be at least 2");
      end
   endgenerate

   word_fmt_e         fmt;
   logic [HALF_W-1:0] hw_old, hw_young;
   logic              pair_ok, pp_old, pp_young, lp_old, lp_young;
   logic              pend_q, accept, finish;

   pd_format #(.HALF_W(HALF_W)) u_fmt (
      .word    (q_word),
      .fmt     (fmt),
      .hw_old  (hw_old),
      .hw_young(hw_young)
   );

   pd_route #(.LONE_ALU_PIPE(LONE_ALU_PIPE)) u_route (
      .cls_old        (op_cls_e'(q_cls_a)),
      .cls_young      (op_cls_e'(q_cls_b)),
      .pair_ok        (pair_ok),
      .pair_pipe_old  (pp_old),
      .pair_pipe_young(pp_young),
      .lone_pipe_old  (lp_old),
      .lone_pipe_young(lp_young)
   );

   pd_phase u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .accept(accept),
      .finish(finish),
      .pend_q(pend_q)
   );

   assign accept    = q_valid && dn_ready;
   assign q_advance = accept && finish;

   always_comb begin
      finish   = 1'b0;
      s0_valid = 1'b0;
      s0_pipe  = 1'b0;
      s0_insn  = '0;
      s1_valid = 1'b0;
      s1_pipe  = 1'b0;
      s1_insn  = '0;
      if (q_valid) begin
         s0_valid = 1'b1;
         if (pend_q) begin
            s0_insn = {{HALF_W{1'b0}}, hw_young};
            s0_pipe = lp_young;
            finish  = 1'b1;
         end else begin
            unique case (fmt)
               FMT_LONG: begin
                  s0_insn = q_word;
                  s0_pipe = lp_old;
                  finish  = 1'b1;
               end
               FMT_PAR: begin
                  s0_insn = {{HALF_W{1'b0}}, hw_old};
                  if (pair_ok) begin
                     s0_pipe  = pp_old;
                     s1_valid = 1'b1;
                     s1_pipe  = pp_young;
                     s1_insn  = {{HALF_W{1'b0}}, hw_young};
                     finish   = 1'b1;
                  end else begin
                     s0_pipe = lp_old;
                  end
               end
               default: begin
                  s0_insn = {{HALF_W{1'b0}}, hw_old};
                  s0_pipe = lp_old;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
   parameter int HALF_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                q_valid,
   input logic [2*HALF_W-1:0] q_word,
   input logic                dn_ready,
   input logic                q_advance,
   input logic                s0_pipe,
   input logic [2*HALF_W-1:0] s0_insn,
   input logic                s1_valid,
   input logic                s1_pipe,
   input logic                pend
);
   localparam int WORD_W = 2 * HALF_W;

   a_r2_long_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_word[WORD_W-1] && !pend) |-> (!s1_valid && s0_insn == q_word));

   a_r3_seq_first_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && !pend && !q_word[WORD_W-1] && !q_word[HALF_W-1]) |-> !q_advance);

   a_r3_advance_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      q_advance |-> (q_valid && dn_ready));

   a_r6_pair_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> (s0_pipe != s1_pipe));

   a_r7_split_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && dn_ready && !q_advance) |=> pend);

   a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && !dn_ready) |=> $stable(pend));

endmodule

bind pair_dispatch pd_checker #(.HALF_W(HALF_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .q_valid  (q_valid),
   .q_word   (q_word),
   .dn_ready (dn_ready),
   .q_advance(q_advance),
   .s0_pipe  (s0_pipe),
   .s0_insn  (s0_insn),
   .s1_valid (s1_valid),
   .s1_pipe  (s1_pipe),
   .pend     (pend_q)
);

// File: tb/sim_pair_dispatch.sv
module sim_pair_dispatch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        q_valid = 1'b0;
   logic [31:0] q_word = '0;
   logic [1:0]  q_cls_a = '0, q_cls_b = '0;
   logic        dn_ready = 1'b0;
   logic        q_advance, s0_valid, s0_pipe, s1_valid, s1_pipe;
   logic [31:0] s0_insn, s1_insn;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit m_pend = 1'b0;

   always #10 clk = ~clk;

   pair_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_word(q_word),
      .q_cls_a(q_cls_a), .q_cls_b(q_cls_b), .dn_ready(dn_ready),
      .q_advance(q_advance), .s0_valid(s0_valid), .s0_pipe(s0_pipe),
      .s0_insn(s0_insn), .s1_valid(s1_valid), .s1_pipe(s1_pipe),
      .s1_insn(s1_insn)
   );

   typedef struct packed {
      logic        v0;
      logic        p0;
      logic [31:0] i0;
      logic        v1;
      logic        p1;
      logic [31:0] i1;
      logic        adv;
   } exp_t;

   function automatic logic lone(logic [1:0] c);
      return (c == 2'b11);
   endfunction

   function automatic logic p1only(logic [1:0] c);
      return (c == 2'b01) || (c == 2'b10);
   endfunction

   function automatic exp_t model(bit pend, logic v, logic [31:0] w,
                                  logic [1:0] ca, logic [1:0] cb, logic rdy);
      exp_t e = '0;
      bit clash;
      if (!v) return e;
      e.v0 = 1'b1;
      clash = (ca == 2'b11 && cb == 2'b11) || (p1only(ca) && p1only(cb));
      if (pend) begin
         e.i0 = {16'h0, w[15:0]}; e.p0 = lone(cb); e.adv = rdy;
      end else if (w[31]) begin
         e.i0 = w; e.p0 = lone(ca); e.adv = rdy;
      end else if (!w[15] || clash) begin
         e.i0 = {16'h0, w[31:16]}; e.p0 = lone(ca);
      end else begin
         e.i0  = {16'h0, w[31:16]};
         e.p0  = (ca == 2'b11) || (ca == 2'b00 && p1only(cb));
         e.v1  = 1'b1;
         e.p1  = !e.p0;
         e.i1  = {16'h0, w[15:0]};
         e.adv = rdy;
      end
      return e;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // drive one cycle, check, and advance the bench phase flag at the edge
   task automatic step(logic v, logic [31:0] w, logic [1:0] ca, logic [1:0] cb, logic rdy);
      exp_t e;
      string ft, pt;
      @(negedge clk);
      q_valid = v; q_word = w; q_cls_a = ca; q_cls_b = cb; dn_ready = rdy;
      #5;
      e = model(m_pend, v, w, ca, cb, rdy);
      if (!v) ft = "R1";
      else if (m_pend) ft = "R3";
      else if (w[31]) ft = "R2";
      else if (!w[15]) ft = "R3";
      else if (e.v1) ft = "R4";
      else ft = "R7";
      if (e.v1) pt = "R6";
      else if (v && !m_pend && ca == 2'b00) pt = "R9";
      else if (v && m_pend && cb == 2'b00) pt = "R9";
      else pt = "R5";
      chk(ft, "s0_valid", 32'(s0_valid), 32'(e.v0));
      chk(ft, "s0_insn", s0_insn, e.i0);
      chk(pt, "s0_pipe", 32'(s0_pipe), 32'(e.p0));
      chk(ft, "s1_valid", 32'(s1_valid), 32'(e.v1));
      chk(ft, "s1_insn", s1_insn, e.i1);
      chk(pt, "s1_pipe", 32'(s1_pipe), 32'(e.p1));
      chk(rdy ? ft : "R8", "q_advance", 32'(q_advance), 32'(e.adv));
      @(posedge clk);
      if (v && rdy) m_pend = !e.adv;
   endtask

   initial begin
      repeat (3) begin
         @(negedge clk); #5;
         chk("R1", "reset s0_valid", 32'(s0_valid), 32'h0);
         chk("R1", "reset q_advance", 32'(q_advance), 32'h0);
         chk("R1", "reset s1_valid", 32'(s1_valid), 32'h0);
      end
      rst_n = 1'b1;
      step(0, 32'h0, 2'b00, 2'b00, 1);
      // R2 long forms
      step(1, 32'h8000_1234, 2'b01, 2'b00, 1);
      step(1, 32'hC0DE_0001, 2'b11, 2'b00, 1);
      step(1, 32'h9000_0000, 2'b00, 2'b00, 1);   // R9 lone ALU
      // R3 sequential pair with a stall in between
      step(1, 32'h1234_5678, 2'b00, 2'b11, 1);
      step(1, 32'h1234_5678, 2'b00, 2'b11, 0);
      step(1, 32'h1234_5678, 2'b00, 2'b11, 1);
      // R4 / R6 legal pairs
      step(1, 32'h1111_9222, 2'b01, 2'b11, 1);
      step(1, 32'h2222_8333, 2'b00, 2'b10, 1);
      step(1, 32'h3333_8444, 2'b11, 2'b00, 1);
      step(1, 32'h4444_8555, 2'b00, 2'b00, 1);
      // R7 illegal pairs split
      step(1, 32'h5555_8666, 2'b01, 2'b01, 1);
      step(1, 32'h5555_8666, 2'b01, 2'b01, 1);
      step(1, 32'h6666_8777, 2'b11, 2'b11, 1);
      step(1, 32'h6666_8777, 2'b11, 2'b11, 1);
      step(1, 32'h7777_8888, 2'b10, 2'b01, 1);
      step(1, 32'h7777_8888, 2'b10, 2'b01, 1);
      // R8 stall on a parallel pair
      step(1, 32'h0101_8202, 2'b00, 2'b11, 0);
      step(1, 32'h0101_8202, 2'b00, 2'b11, 0);
      step(1, 32'h0101_8202, 2'b00, 2'b11, 1);
      // constrained random, word held until advance
      begin
         logic [31:0] w;
         logic [1:0] ca, cb;
         bit pop;
         void'($urandom(32'd1234));
         pop = 1'b1;
         w = '0; ca = '0; cb = '0;
         for (int i = 0; i < 3000; i++) begin
            logic v, r;
            if (pop) begin
               w = $urandom;
               if ($urandom_range(2) == 0) w[31] = 1'b1;
               ca = 2'($urandom_range(3));
               cb = 2'($urandom_range(3));
            end
            v = ($urandom_range(7) != 0);
            r = ($urandom_range(3) != 0);
            pop = v && r && (model(m_pend, v, w, ca, cb, r).adv);
            step(v, w, ca, cb, r);
         end
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule